// File: doc/BRIEF.md
# Selectable-Clock Aligned PWM Channel

This block produces one pulse-width modulated output from a master clock. The channel counter does not advance on every master clock. It steps on a channel tick, and the tick comes from one of three places: a free-running power-of-two prescaler with eleven ratios (1 up to 1024), or one of two linear dividers whose 8-bit ratios are loaded independently. The counter runs against a 16-bit period value and a 16-bit duty value. In left-aligned mode it ramps up and wraps. In center-aligned mode it ramps up and then back down, which doubles the output period and gives waveforms that are symmetric about the middle of the period.

Software-side logic programs the channel through three write strobes: mode, period and duty. Two further strobes load the dividers. Period and duty writes land in shadow copies. These copies move into the active compare state only at a period boundary, or at once while the channel is disabled, so a running waveform never gets a truncated or doubled pulse. The output starts each period at a programmable start level. It keeps that level while the counter is below the duty value and takes the opposite level from there to the end of the period.

Top module: `pwmch_top`

## Requirements
- R1: After reset the channel is disabled, the mode is left-aligned with start level low, and `pwm_out` is 0.
- R2: A mode word of layout {start_high[5], center[4], clk_sel[3:0]}, with clk_sel k in 0..10, clocks the channel every 2^k master clocks. In left-aligned mode the output period is then P·2^k master clocks for period value P.
- R3: In left-aligned mode with 0 < D < P, the output spends (P−D)·X master clocks per period at the level opposite the start level and D·X at the start level. X is the tick spacing. With start low, the high time is (P−D)·X; with start high, it is D·X.
- R4: In center-aligned mode (mode bit 4 set) the output period is 2·P·X. The opposite-level time is 2·(P−D)·X, in one contiguous pulse centered in the period.
- R5: clk_sel 11 selects linear divider A and clk_sel 12 selects divider B. A divider loaded with N ≥ 1 gives one tick every N master clocks.
- R6: A divider loaded with 0 gives no ticks, and clk_sel 13..15 select no tick source. In both cases the counter and the output stay frozen.
- R7: A duty value D ≥ P holds the output at the start level for the whole period. D = 0 holds it at the opposite level.
- R8: While the channel runs, period and duty writes take effect only at the next period boundary. While the channel is disabled they take effect at once.
- R9: While `enable` is low the output stays at the start level and the counter is held at 0. After `enable` rises the counter starts from 0, one master clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel run enable |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 6 | Mode word: start level, alignment, clock select |
| period_we | input | 1 | Period write strobe |
| period_wdata | input | 16 | Period value |
| duty_we | input | 1 | Duty write strobe |
| duty_wdata | input | 16 | Duty value |
| diva_we | input | 1 | Divider A load strobe |
| divb_we | input | 1 | Divider B load strobe |
| div_wdata | input | 8 | Divider ratio (0 = off) |
| pwm_out | output | 1 | PWM waveform |

## Verification
Every cycle, the assertions check the following:
- the channel counter stays below the active period, stays frozen between ticks and is cleared while disabled;
- the active duty changes only at a period boundary;
- the count direction stays up in left-aligned mode;
- divider and prescaler ticks never repeat on consecutive clocks when the ratio exceeds one.

The lengths that matter to a user cannot be seen in a single cycle. These are the measured periods and pulse widths for each prescaler ratio, both alignments and both start levels, the divider ratios, the deferred duty update and the enable-to-first-edge delay. Only the bench scenarios show them, by timing edges in master clocks.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;
   typedef enum logic {
      ALIGN_LEFT   = 1'b0,
      ALIGN_CENTER = 1'b1
   } align_e;

   localparam int NUM_LIN_DIV = 2;
endpackage

// File: rtl/pwmch_prescaler.sv
// Free-running power-of-two tick generator: tick[k] pulses once every 2^k clocks.
module pwmch_prescaler #(
   parameter int STAGES = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [STAGES-1:0] tick
);
   localparam int CW = (STAGES > 1) ? STAGES - 1 : 1;

   logic [CW-1:0] pre_cnt;

   if (STAGES < 1) begin : g_bad_stages
      $error("pwmch_prescaler: STAGES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_cnt <= '0;
      else        pre_cnt <= pre_cnt + 1'b1;
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_tap
      if (k == 0) begin : g_unit
         assign tick[k] = 1'b1;
      end else begin : g_pow
         assign tick[k] = &pre_cnt[k-1:0];

         AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            tick[k] |=> !tick[k]); // R2
      end
   end
endmodule

// File: rtl/pwmch_lindiv.sv
// Linear divider: ratio N gives one tick every N clocks, N = 0 stops it.
module pwmch_lindiv #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         tick
);
   logic [W-1:0] ratio_q;
   logic [W-1:0] phase_q;

   if (W < 1) begin : g_bad_w
      $error("pwmch_lindiv: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= '0;
         phase_q <= '0;
      end else if (load) begin
         ratio_q <= load_val;
         phase_q <= '0;
      end else if (ratio_q != '0) begin
         phase_q <= tick ? '0 : phase_q + 1'b1;
      end
   end

   assign tick = (ratio_q != '0) && (phase_q == ratio_q - 1'b1);

   AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ratio_q > 1 && !load) |=> !tick); // R5
   AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q == '0 && !load) |=> $stable(phase_q)); // R6
endmodule

// File: rtl/pwmch_core.sv
// Channel counter, shadowed period/duty and output compare.
module pwmch_core
   import pwmch_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  align_e           align,
   input  logic             start_high,
   input  logic             period_we,
   input  logic [CNT_W-1:0] period_wdata,
   input  logic             duty_we,
   input  logic [CNT_W-1:0] duty_wdata,
   output logic             pwm_out
);
   logic             en_q;
   logic [CNT_W-1:0] per_sh, duty_sh;
   logic [CNT_W-1:0] per_act, duty_act;
   logic [CNT_W-1:0] cnt;
   logic             dir_down;
   logic [CNT_W-1:0] per_eff;
   logic             at_top;
   logic             boundary;

   if (CNT_W < 2) begin : g_bad_w
      $error("pwmch_core: CNT_W must be at least 2");
   end

   assign per_eff  = (per_act == '0) ? CNT_W'(1) : per_act;
   assign at_top   = (cnt == per_eff - 1'b1);
   assign boundary = tick && ((align == ALIGN_LEFT) ? at_top : (dir_down && cnt == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= enable;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_sh  <= '0;
         duty_sh <= '0;
      end else begin
         if (period_we) per_sh  <= period_wdata;
         if (duty_we)   duty_sh <= duty_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_act  <= '0;
         duty_act <= '0;
      end else if (!en_q || boundary) begin
         per_act  <= per_sh;
         duty_act <= duty_sh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         dir_down <= 1'b0;
      end else if (!en_q) begin
         cnt      <= '0;
         dir_down <= 1'b0;
      end else if (align == ALIGN_LEFT) begin
         dir_down <= 1'b0;
         if (tick) cnt <= at_top ? '0 : cnt + 1'b1;
      end else if (tick) begin
         if (!dir_down) begin
            if (at_top) dir_down <= 1'b1;
            else        cnt      <= cnt + 1'b1;
         end else begin
            if (cnt == '0) dir_down <= 1'b0;
            else           cnt      <= cnt - 1'b1;
         end
      end
   end

   assign pwm_out = en_q ? ((cnt < duty_act) ? start_high : !start_high) : start_high;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> (cnt < per_eff)); // R2
   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !tick) |=> $stable(cnt)); // R6
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (cnt == '0)); // R9
   AST_DUTY_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !boundary) |=> $stable(duty_act)); // R8
   AST_PER_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !boundary) |=> $stable(per_act)); // R8
   AST_LEFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (align == ALIGN_LEFT) |=> !dir_down); // R4
endmodule

// File: rtl/pwmch_top.sv
module pwmch_top
   import pwmch_pkg::*;
#(
   parameter int STAGES = 11,
   parameter int SEL_W  = 4,
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 8,
   localparam int MODE_W = SEL_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              period_we,
   input  logic [CNT_W-1:0]  period_wdata,
   input  logic              duty_we,
   input  logic [CNT_W-1:0]  duty_wdata,
   input  logic              diva_we,
   input  logic              divb_we,
   input  logic [DIV_W-1:0]  div_wdata,
   output logic              pwm_out
);
   typedef struct packed {
      logic              start_high;
      align_e            align;
      logic [SEL_W-1:0]  clk_sel;
   } mode_t;

   mode_t                  mode_q;
   logic [STAGES-1:0]      pre_tick;
   logic [NUM_LIN_DIV-1:0] div_load;
   logic [NUM_LIN_DIV-1:0] div_tick;
   logic                   chan_tick;

   if (STAGES < 1 || STAGES + NUM_LIN_DIV > (1 << SEL_W)) begin : g_bad_sel
      $error("pwmch_top: SEL_W too narrow for STAGES plus dividers");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_we) mode_q <= mode_t'(mode_wdata);
   end

   pwmch_prescaler #(.STAGES(STAGES)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (pre_tick)
   );

   assign div_load = {divb_we, diva_we};

   for (genvar d = 0; d < NUM_LIN_DIV; d++) begin : g_div
      pwmch_lindiv #(.W(DIV_W)) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (div_load[d]),
         .load_val (div_wdata),
         .tick     (div_tick[d])
      );
   end

   always_comb begin
      chan_tick = 1'b0;
      for (int k = 0; k < STAGES; k++) begin
         if (mode_q.clk_sel == SEL_W'(k)) chan_tick = pre_tick[k];
      end
      for (int d = 0; d < NUM_LIN_DIV; d++) begin
         if (mode_q.clk_sel == SEL_W'(STAGES + d)) chan_tick = div_tick[d];
      end
   end

   pwmch_core #(.CNT_W(CNT_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .tick         (chan_tick),
      .align        (mode_q.align),
      .start_high   (mode_q.start_high),
      .period_we    (period_we),
      .period_wdata (period_wdata),
      .duty_we      (duty_we),
      .duty_wdata   (duty_wdata),
      .pwm_out      (pwm_out)
   );

   AST_NO_TICK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.clk_sel >= SEL_W'(STAGES + NUM_LIN_DIV)) |-> !chan_tick); // R6
endmodule

// File: tb/sim_pwmch_top.sv
`timescale 1ns/1ps
module sim_pwmch_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        mode_we = 1'b0;
   logic [5:0]  mode_wdata = '0;
   logic        period_we = 1'b0;
   logic [15:0] period_wdata = '0;
   logic        duty_we = 1'b0;
   logic [15:0] duty_wdata = '0;
   logic        diva_we = 1'b0;
   logic        divb_we = 1'b0;
   logic [7:0]  div_wdata = '0;
   logic        pwm_out;

   int cyc = 0;
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwmch_top u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .mode_we(mode_we), .mode_wdata(mode_wdata),
      .period_we(period_we), .period_wdata(period_wdata),
      .duty_we(duty_we), .duty_wdata(duty_wdata),
      .diva_we(diva_we), .divb_we(divb_we), .div_wdata(div_wdata),
      .pwm_out(pwm_out)
   );

   task automatic check(input int act, input int exp, input string req, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_mode(input int sel, input int algn, input int pol);
      @(negedge clk);
      mode_wdata = 6'((pol << 5) | (algn << 4) | sel);
      mode_we = 1'b1;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   task automatic write_period(input int p);
      @(negedge clk);
      period_wdata = 16'(p);
      period_we = 1'b1;
      @(negedge clk);
      period_we = 1'b0;
   endtask

   task automatic write_duty(input int d);
      @(negedge clk);
      duty_wdata = 16'(d);
      duty_we = 1'b1;
      @(negedge clk);
      duty_we = 1'b0;
   endtask

   task automatic write_div(input int which, input int v);
      @(negedge clk);
      div_wdata = 8'(v);
      if (which == 0) diva_we = 1'b1; else divb_we = 1'b1;
      @(negedge clk);
      diva_we = 1'b0;
      divb_we = 1'b0;
   endtask

   task automatic setup(input int sel, input int algn, input int pol, input int p, input int d);
      @(negedge clk);
      enable = 1'b0;
      write_mode(sel, algn, pol);
      write_period(p);
      write_duty(d);
      idle(2);
      enable = 1'b1;
   endtask

   task automatic wait_level(input logic lvl, input int lim, output int t, output bit ok);
      ok = 1'b0;
      t = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (pwm_out == lvl) begin
            ok = 1'b1;
            t = cyc;
            break;
         end
      end
   endtask

   task automatic measure(input int lim, output int per, output int high);
      int ta, t0, t1, t2;
      bit k0, k1, k2, k3;
      wait_level(1'b0, lim, ta, k0);
      wait_level(1'b1, lim, t0, k1);
      wait_level(1'b0, lim, t1, k2);
      wait_level(1'b1, lim, t2, k3);
      if (k0 && k1 && k2 && k3) begin
         per = t2 - t0;
         high = t1 - t0;
      end else begin
         per = -1;
         high = -1;
      end
   endtask

   task automatic count_toggles(input int n, output int toggles, output int level);
      logic prev;
      toggles = 0;
      @(negedge clk);
      prev = pwm_out;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out != prev) toggles++;
         prev = pwm_out;
      end
      level = int'(pwm_out);
   endtask

   function automatic int exp_high(input int p, input int d, input int x, input int algn, input int pol);
      return (pol != 0 ? d : p - d) * x * (algn != 0 ? 2 : 1);
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      int per, hi, tg, lv, n, m, t0, t1, t2, t3, c0;
      bit ok;
      void'($urandom(32'h1f2e3d4c));
      idle(3);
      rst_n = 1'b1;
      idle(3);
      check(int'(pwm_out), 0, "R1", "reset output level");

      // R2 / R3 / R4: every prescaler ratio, both alignments, both start levels
      for (int k = 0; k < 11; k++) begin
         for (int a = 0; a < 2; a++) begin
            for (int pl = 0; pl < 2; pl++) begin
               int p, d, x, mul;
               x = 1 << k;
               mul = (a != 0) ? 2 : 1;
               if (k < 7) begin
                  p = 2 + int'($urandom % 14);
                  d = 1 + int'($urandom % (p - 1));
               end else begin
                  p = 2;
                  d = 1;
               end
               setup(k, a, pl, p, d);
               measure(3 * p * x * mul + 16, per, hi);
               check(per, p * x * mul, (a != 0) ? "R4" : "R2", $sformatf("period sel=%0d pol=%0d", k, pl));
               check(hi, exp_high(p, d, x, a, pl), (a != 0) ? "R4" : "R3",
                     $sformatf("high time sel=%0d pol=%0d", k, pl));
            end
         end
      end

      // R5: linear dividers A and B
      n = 3 + int'($urandom % 18);
      m = 3 + int'($urandom % 18);
      write_div(0, n);
      write_div(1, m);
      setup(11, 0, 0, 5, 2);
      measure(15 * n + 16, per, hi);
      check(per, 5 * n, "R5", "divider A period");
      check(hi, 3 * n, "R5", "divider A high time");
      setup(12, 1, 0, 5, 2);
      measure(30 * m + 16, per, hi);
      check(per, 10 * m, "R5", "divider B center period");
      check(hi, 6 * m, "R5", "divider B center high time");

      // R6: divider off and unused selector codes freeze the output
      write_div(0, 0);
      setup(11, 0, 0, 5, 2);
      idle(4);
      count_toggles(300, tg, lv);
      check(tg, 0, "R6", "toggles with divider off");
      check(lv, 0, "R6", "level with divider off");
      setup(13, 0, 1, 5, 2);
      idle(4);
      count_toggles(300, tg, lv);
      check(tg, 0, "R6", "toggles with empty selector");
      check(lv, 1, "R6", "level with empty selector");

      // R7: duty at or above period, and duty zero
      setup(0, 0, 0, 4, 4);
      idle(4);
      count_toggles(40, tg, lv);
      check(tg, 0, "R7", "toggles duty==period");
      check(lv, 0, "R7", "level duty==period");
      setup(2, 1, 1, 3, 7);
      idle(4);
      count_toggles(80, tg, lv);
      check(tg, 0, "R7", "toggles duty>period center");
      check(lv, 1, "R7", "level duty>period center");
      setup(1, 0, 0, 6, 0);
      idle(4);
      count_toggles(60, tg, lv);
      check(tg, 0, "R7", "toggles duty zero");
      check(lv, 1, "R7", "level duty zero");

      // R9: disabled holds start level; enable starts counting from zero
      setup(0, 0, 1, 8, 3);
      @(negedge clk);
      enable = 1'b0;
      idle(3);
      count_toggles(50, tg, lv);
      check(tg, 0, "R9", "toggles while disabled");
      check(lv, 1, "R9", "level while disabled");
      @(negedge clk);
      enable = 1'b1;
      c0 = cyc;
      idle(2);
      check(int'(pwm_out), 1, "R9", "start level just after enable");
      wait_level(1'b0, 100, t0, ok);
      check(ok ? t0 - c0 : -1, 4, "R9", "enable to first edge");

      // R8: duty written mid-period applies at the next boundary
      setup(0, 0, 0, 20, 5);
      wait_level(1'b1, 100, t0, ok);
      write_duty(15);
      wait_level(1'b0, 100, t1, ok);
      wait_level(1'b1, 100, t2, ok);
      wait_level(1'b0, 100, t3, ok);
      check(t1 - t0, 15, "R8", "high time of current period kept");
      check(t2 - t1, 15, "R8", "low time with new duty");
      check(t3 - t2, 5, "R8", "high time with new duty");

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule